// File: doc/BRIEF.md
# Three-Port Register File with Zero Register

This block is the general-purpose register store of a small processor datapath. It holds sixteen 16-bit registers and serves one instruction per cycle: two source operands are read through independent combinational ports while a result is written through a single port that updates on the rising clock edge. The write lands only when its enable is high.

Register index 0 is fixed at zero. Writes aimed at it are discarded, so software can use it as a constant zero source and as a sink for unwanted results. The whole file can be zeroed in one cycle either by the synchronous active-low reset or by a synchronous clear input used during operation. Clear takes priority over a write in the same cycle. A read of the register being written in the same cycle returns the value held before the edge.

Top module: `regfile_3p`

## Requirements
- R1: One rising clock edge with `rst_n` low sets every register to zero, so both read ports return 0x0000 for every select afterwards.
- R2: With `wr_en` high, `clr` low and `wr_sel` nonzero, `wr_data` is stored in register `wr_sel` at the rising edge and is returned by any read port selecting that register afterwards.
- R3: With `wr_en` low, a rising edge leaves every register unchanged.
- R4: The two read ports are independent: each returns the register named by its own select in the same cycle, including while a write is pending.
- R5: Reads are combinational; a read of the register being written in the current cycle returns the old value until the edge, and the new value after it.
- R6: Register 0 always reads 0x0000, and writes with `wr_sel` = 0 change no register.
- R7: A rising edge with `clr` high and `rst_n` high sets every register to zero.
- R8: When `clr` and `wr_en` are both high in one cycle, the clear wins and the targeted register reads zero afterwards.
- R9: A write changes only the register it selects; all other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes, clear and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, zeroes all registers |
| clr | input | 1 | Synchronous clear, zeroes all registers, beats a write |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 4 | Destination register index |
| wr_data | input | 16 | Value to store |
| rd_sel_a | input | 4 | Source register index for port A |
| rd_sel_b | input | 4 | Source register index for port B |
| rd_data_a | output | 16 | Contents of register `rd_sel_a` |
| rd_data_b | output | 16 | Contents of register `rd_sel_b` |

## Verification
Because the read paths hold no state, any corrupted register content is visible on a read port in the same cycle the bad register is selected, one edge after the faulty update. A decoder that hits the wrong register shows up as a changed neighbour or a stale target when all sixteen registers are read back after distinct writes. A zero register that accepts writes, or a clear that loses to a write, appears at the ports on the very next read of that index.

// File: rtl/rf_pkg.sv
// Package: shared sizing for the three-port register file.
// Assumes a power-of-two register count so every select value is a valid index.
package rf_pkg;
    localparam int RF_NUM_REGS = 16;
    localparam int RF_DATA_W   = 16;
    localparam int RF_SEL_W    = $clog2(RF_NUM_REGS);
    localparam int RF_RD_PORTS = 2;
endpackage

// File: rtl/rf_wr_decode.sv
// Module: write-select decoder.
// Turns the write index into a one-hot strobe gated by the enable.
// Index 0 gets no strobe at all, which is what keeps the zero register fixed.
module rf_wr_decode #(
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int SEL_W    = rf_pkg::RF_SEL_W
) (
    input  logic              en,
    input  logic [SEL_W-1:0]  sel,
    output logic [NUM_REGS-1:1] strobe
);
    // One comparator per writable register.
    for (genvar i = 1; i < NUM_REGS; i++) begin : g_dec
        assign strobe[i] = en && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/rf_storage.sv
// Module: register storage array.
// Holds NUM_REGS-1 writable words; slot 0 is a constant zero.
// Assumes at most one strobe is active per cycle; reset and clear override it.
module rf_storage #(
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::RF_DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic [NUM_REGS-1:1]        strobe,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] flat
);
    // Slot 0 is tied to zero; it has no storage at all.
    assign flat[DATA_W-1:0] = '0;

    for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
        logic [DATA_W-1:0] word_q;

        // Zero on reset or clear, otherwise load when strobed.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                word_q <= '0;
            end else if (strobe[i]) begin
                word_q <= wr_data;
            end
        end

        assign flat[i*DATA_W +: DATA_W] = word_q;
    end
endmodule

// File: rtl/rf_read_mux.sv
// Module: one combinational read port.
// Selects one word from the flattened array; no state, so the
// output follows the select and the stored contents within the cycle.
module rf_read_mux #(
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int SEL_W    = rf_pkg::RF_SEL_W
) (
    input  logic [NUM_REGS*DATA_W-1:0] flat,
    input  logic [SEL_W-1:0]           sel,
    output logic [DATA_W-1:0]          data
);
    // Index the selected word; out-of-range selects read zero.
    always_comb begin
        data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel == SEL_W'(i)) begin
                data = flat[i*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/regfile_3p.sv
// Module: three-port register file, top level.
// Two combinational read ports and one edge-triggered write port.
// Assumes rst_n and clr are synchronous to clk; register 0 is always zero.
module regfile_3p #(
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int SEL_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel_a,
    input  logic [SEL_W-1:0]  rd_sel_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    localparam int RD_PORTS = rf_pkg::RF_RD_PORTS;

    logic [NUM_REGS-1:1]        strobe;
    logic [NUM_REGS*DATA_W-1:0] flat;
    logic [SEL_W-1:0]           rd_sel  [RD_PORTS];
    logic [DATA_W-1:0]          rd_data [RD_PORTS];

    rf_wr_decode #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_dec (
        .en     (wr_en),
        .sel    (wr_sel),
        .strobe (strobe)
    );

    rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .strobe  (strobe),
        .wr_data (wr_data),
        .flat    (flat)
    );

    assign rd_sel[0] = rd_sel_a;
    assign rd_sel[1] = rd_sel_b;

    // One independent multiplexer per read port.
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        rf_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_mux (
            .flat (flat),
            .sel  (rd_sel[p]),
            .data (rd_data[p])
        );
    end

    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];
endmodule

// File: rtl/regfile_3p_chk.sv
// Module: protocol checker for the register file, bound to the top.
// Observes ports only.
module regfile_3p_chk #(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [SEL_W-1:0]  rd_sel_a,
    input logic [SEL_W-1:0]  rd_sel_b,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [DATA_W-1:0] rd_data_b
);
    AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_sel_a == '0) |-> (rd_data_a == '0)) and ((rd_sel_b == '0) |-> (rd_data_b == '0))); // R6

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && (wr_sel != '0)) |=>
        ((rd_sel_a != $past(wr_sel)) || (rd_data_a == $past(wr_data)))); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr) |=>
        ((rd_sel_a != $past(rd_sel_a)) || (rd_data_a == $past(rd_data_a)))); // R3

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((rd_data_a == '0) && (rd_data_b == '0))); // R7

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && wr_en) |=> ((rd_sel_b != $past(wr_sel)) || (rd_data_b == '0))); // R8
endmodule

bind regfile_3p regfile_3p_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_sel_a  (rd_sel_a),
    .rd_sel_b  (rd_sel_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b)
);

// File: tb/regfile_3p_tb_top.sv
`timescale 1ns/1ps
module regfile_3p_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_sel_a = '0;
    logic [3:0]  rd_sel_b = '0;
    logic [15:0] rd_data_a;
    logic [15:0] rd_data_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    regfile_3p dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel_a(rd_sel_a), .rd_sel_b(rd_sel_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
    );

    // Vector: {we, wr_sel, wr_data, rd_a, rd_b, exp_a, exp_b}; expectations are pre-edge reads.
    localparam int NVEC = 8;
    localparam logic [60:0] VEC [NVEC] = '{
        {1'b1, 4'd3,  16'hA5A5, 4'd3,  4'd0,  16'h0000, 16'h0000},
        {1'b1, 4'd7,  16'h1234, 4'd3,  4'd7,  16'hA5A5, 16'h0000},
        {1'b0, 4'd3,  16'hFFFF, 4'd3,  4'd7,  16'hA5A5, 16'h1234},
        {1'b1, 4'd0,  16'hBEEF, 4'd3,  4'd7,  16'hA5A5, 16'h1234},
        {1'b0, 4'd0,  16'h0000, 4'd0,  4'd0,  16'h0000, 16'h0000},
        {1'b1, 4'd15, 16'h8001, 4'd15, 4'd3,  16'h0000, 16'hA5A5},
        {1'b1, 4'd3,  16'h0F0F, 4'd15, 4'd7,  16'h8001, 16'h1234},
        {1'b0, 4'd0,  16'h0000, 4'd3,  4'd15, 16'h0F0F, 16'h8001}
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write(input logic [3:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic read_all_zero(input string req);
        for (int i = 0; i < 16; i++) begin
            rd_sel_a = 4'(i); rd_sel_b = 4'(15 - i);
            #1;
            check(req, rd_data_a, 16'h0000);
            check(req, rd_data_b, 16'h0000);
        end
    endtask

    task automatic fill_pattern();
        for (int i = 1; i < 16; i++) write(4'(i), 16'h1111 * 16'(i) ^ 16'h5A00);
    endtask

    initial begin
        repeat (3) tick();
        read_all_zero("R1 reset");
        rst_n = 1'b1;
        tick();

        // Vector table: R2 R3 R4 R5 R6 R9
        for (int v = 0; v < NVEC; v++) begin
            wr_en = VEC[v][60]; wr_sel = VEC[v][59:56]; wr_data = VEC[v][55:40];
            rd_sel_a = VEC[v][39:36]; rd_sel_b = VEC[v][35:32];
            #1;
            check("R4/R5 vector port A", rd_data_a, VEC[v][31:16]);
            check("R4/R5 vector port B", rd_data_b, VEC[v][15:0]);
            tick();
        end
        wr_en = 1'b0;

        // R5: same-cycle read of the target returns old, then new.
        rd_sel_a = 4'd7; wr_en = 1'b1; wr_sel = 4'd7; wr_data = 16'hC0DE;
        #1; check("R5 old value", rd_data_a, 16'h1234);
        tick(); wr_en = 1'b0;
        #1; check("R5 new value", rd_data_a, 16'hC0DE);

        // R9 and R2: distinct value per register, full read-back on both ports.
        fill_pattern();
        for (int i = 1; i < 16; i++) begin
            rd_sel_a = 4'(i); rd_sel_b = 4'(i);
            #1;
            check("R9 readback A", rd_data_a, 16'h1111 * 16'(i) ^ 16'h5A00);
            check("R2 readback B", rd_data_b, 16'h1111 * 16'(i) ^ 16'h5A00);
        end

        // R6: write to register 0 then read it.
        write(4'd0, 16'hFFFF);
        rd_sel_a = 4'd0; rd_sel_b = 4'd1; #1;
        check("R6 zero reg", rd_data_a, 16'h0000);
        check("R6 neighbour kept", rd_data_b, 16'h1111 ^ 16'h5A00);

        // R3: disabled write of a new value does not land.
        wr_en = 1'b0; wr_sel = 4'd5; wr_data = 16'hDEAD; tick();
        rd_sel_a = 4'd5; #1;
        check("R3 disabled write", rd_data_a, 16'h5555 ^ 16'h5A00);

        // R7: clear zeroes everything.
        clr = 1'b1; tick(); clr = 1'b0;
        read_all_zero("R7 clear");

        // R8: clear together with a write.
        write(4'd9, 16'h7777);
        clr = 1'b1; wr_en = 1'b1; wr_sel = 4'd9; wr_data = 16'h4242;
        tick();
        clr = 1'b0; wr_en = 1'b0;
        rd_sel_a = 4'd9; rd_sel_b = 4'd9; #1;
        check("R8 clear wins", rd_data_a, 16'h0000);

        // R1: reset in mid-run.
        fill_pattern();
        rst_n = 1'b0; tick();
        read_all_zero("R1 midrun reset");
        rst_n = 1'b1; tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule